// File: doc/BRIEF.md
# Zero-Data Mute Controller

This block decides when an external analog muting circuit should be engaged. It sees the samples of six audio channels, each delivered together with one valid strobe. It also sees four status levels from the rest of the converter: reset in progress, initialization in progress, power-down, and an invalid master-to-frame clock ratio. From these it drives a single active-high, registered mute output.

Mute is forced on by any of the four status conditions. Silence can also turn mute on. The block counts consecutive strobes on which every one of the six channels carries a zero word. When that run reaches a programmable length (8192 by default), mute turns on. The first strobe that carries a non-zero word on any channel restarts the run and releases mute on the same clock edge. Two conditions clear the run: the reset status and the bad-ratio status. The initialization and power-down conditions mute the output but leave the run intact.

Top module: `zero_mute_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mute_o` is 1.
- R2: `in_reset_i` high at a clock edge makes `mute_o` 1 after that edge, and it also clears the zero run. After the status drops, a fresh run of ZERO_RUN zero strobes is needed before silence mutes again.
- R3: `init_busy_i` high at a clock edge makes `mute_o` 1 after that edge.
- R4: `pwr_down_i` high at a clock edge makes `mute_o` 1 after that edge.
- R5: `ratio_bad_i` high at a clock edge makes `mute_o` 1 after that edge and clears the zero run.
- R6: When no status input is high, `mute_o` becomes 1 on the edge that captures the ZERO_RUN-th consecutive strobe on which all channels are zero.
- R7: After only ZERO_RUN-1 such strobes, `mute_o` stays 0.
- R8: A strobe on which any channel word is non-zero makes `mute_o` 0 on that edge, unless a status input is high, and it restarts the run. A strobe on which only some channels are zero never advances the run.
- R9: Cycles with `smp_valid_i` low neither advance nor clear the run.
- R10: The run saturates at ZERO_RUN. Further zero strobes keep `mute_o` at 1 and never wrap.
- R11: Channel c occupies bits [c*SAMPLE_W +: SAMPLE_W] of `smp_data_i`. Channel 0 is at the bottom of the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | One strobe per frame of six samples |
| smp_data_i | input | CHANNELS*SAMPLE_W | Packed channel words, channel 0 lowest |
| in_reset_i | input | 1 | Converter reset status |
| init_busy_i | input | 1 | Initialization in progress |
| pwr_down_i | input | 1 | Power-down in progress |
| ratio_bad_i | input | 1 | Clock ratio invalid |
| mute_o | output | 1 | Registered active-high mute request |

## Verification
The checker verifies the following on every cycle:
- each status input forces mute on the following edge;
- a non-zero strobe releases mute when no status input is high;
- the run counter never passes its limit;
- an idle cycle leaves the counter unchanged;
- a full counter always shows as mute.

Some behaviours depend on long sequences, so only the bench scenarios can show them:
- the exact strobe on which silence mutes, counted across idle gaps;
- that a partially zero frame never counts;
- that the bad-ratio and reset statuses really discard a nearly complete run.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  localparam int unsigned DEF_CHANNELS = 6;
  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_ZERO_RUN = 8192;

  typedef struct packed {
    logic in_reset;
    logic init_busy;
    logic pwr_down;
    logic ratio_bad;
  } mute_cause_t;
endpackage

// File: rtl/zm_rst_sync.sv
module zm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/zm_zero_detect.sv
module zm_zero_detect #(
  parameter int unsigned CHANNELS = 6,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [CHANNELS*SAMPLE_W-1:0] data_i,
  output logic                         all_zero_o
);
  logic [CHANNELS-1:0] ch_zero;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign ch_zero[c] = ~|data_i[c*SAMPLE_W +: SAMPLE_W];
  end

  assign all_zero_o = &ch_zero;
endmodule

// File: rtl/zm_run_counter.sv
module zm_run_counter #(
  parameter int unsigned ZERO_RUN = 8192,
  localparam int unsigned CNT_W   = $clog2(ZERO_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_next_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | adv_i;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      if (!zero_i) begin
        cnt_d = '0;
      end else if (cnt_q != LIMIT) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign full_next_o = (cnt_d == LIMIT);
endmodule

// File: rtl/zero_mute_ctrl.sv
module zero_mute_ctrl
  import zmute_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned ZERO_RUN = DEF_ZERO_RUN,
  localparam int unsigned DATA_W  = CHANNELS * SAMPLE_W,
  localparam int unsigned CNT_W   = $clog2(ZERO_RUN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              in_reset_i,
  input  logic              init_busy_i,
  input  logic              pwr_down_i,
  input  logic              ratio_bad_i,
  output logic              mute_o
);
  mute_cause_t      cause;
  logic             rst_sync_n;
  logic             all_zero;
  logic             run_clr;
  logic             run_full_next;
  logic [CNT_W-1:0] run_cnt;
  logic             mute_d;
  logic             mute_q;

  assign cause.in_reset  = in_reset_i;
  assign cause.init_busy = init_busy_i;
  assign cause.pwr_down  = pwr_down_i;
  assign cause.ratio_bad = ratio_bad_i;

  zm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  zm_zero_detect #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_zero (
    .data_i    (smp_data_i),
    .all_zero_o(all_zero)
  );

  assign run_clr = cause.in_reset | cause.ratio_bad;

  zm_run_counter #(.ZERO_RUN(ZERO_RUN)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .clr_i      (run_clr),
    .adv_i      (smp_valid_i),
    .zero_i     (all_zero),
    .cnt_o      (run_cnt),
    .full_next_o(run_full_next)
  );

  always_comb begin
    mute_d = (|cause) | run_full_next;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mute_q <= 1'b1;
    end else begin
      mute_q <= mute_d;
    end
  end

  assign mute_o = mute_q;
endmodule

// File: rtl/zero_mute_ctrl_chk.sv
module zero_mute_ctrl_chk #(
  parameter int unsigned DATA_W   = 144,
  parameter int unsigned ZERO_RUN = 8192,
  parameter int unsigned CNT_W    = 14
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic              smp_valid_i,
  input logic [DATA_W-1:0] smp_data_i,
  input logic              in_reset_i,
  input logic              init_busy_i,
  input logic              pwr_down_i,
  input logic              ratio_bad_i,
  input logic [CNT_W-1:0]  run_cnt,
  input logic              mute_o
);
  logic any_status;
  assign any_status = in_reset_i | init_busy_i | pwr_down_i | ratio_bad_i;

  // R2
  in_reset_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    in_reset_i |=> (mute_o && run_cnt == '0));
  // R3
  init_busy_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    init_busy_i |=> mute_o);
  // R4
  pwr_down_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    pwr_down_i |=> mute_o);
  // R5
  ratio_bad_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ratio_bad_i |=> (mute_o && run_cnt == '0));
  // R8
  nonzero_release_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (smp_valid_i && (|smp_data_i) && !any_status) |=> (!mute_o && run_cnt == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!smp_valid_i && !in_reset_i && !ratio_bad_i) |=> $stable(run_cnt));
  // R10
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    run_cnt <= CNT_W'(ZERO_RUN));
  // R6
  full_run_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (run_cnt == CNT_W'(ZERO_RUN)) |-> mute_o);
endmodule

bind zero_mute_ctrl zero_mute_ctrl_chk #(
  .DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .smp_valid_i(smp_valid_i),
  .smp_data_i (smp_data_i),
  .in_reset_i (in_reset_i),
  .init_busy_i(init_busy_i),
  .pwr_down_i (pwr_down_i),
  .ratio_bad_i(ratio_bad_i),
  .run_cnt    (run_cnt),
  .mute_o     (mute_o)
);

// File: tb/tb_zero_mute_ctrl.sv
module tb_zero_mute_ctrl;
  localparam int CH   = 6;
  localparam int W    = 24;
  localparam int RUN  = 8192;
  localparam int DW   = CH * W;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          smp_valid_i;
  logic [DW-1:0] smp_data_i;
  logic          in_reset_i, init_busy_i, pwr_down_i, ratio_bad_i;
  logic          mute_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int  m_run = 0;
  bit  m_mute = 1'b1;

  always #4 clk = ~clk;

  zero_mute_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .in_reset_i(in_reset_i),
    .init_busy_i(init_busy_i), .pwr_down_i(pwr_down_i),
    .ratio_bad_i(ratio_bad_i), .mute_o(mute_o)
  );

  function automatic logic [DW-1:0] one_ch(input int c, input logic [W-1:0] v);
    logic [DW-1:0] r = '0;
    r[c*W +: W] = v;
    return r;
  endfunction

  // behavioural model (R2 R5 R6 R8 R9 R10)
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run  = 0;
      m_mute = 1'b1;
    end else begin
      if (in_reset_i || ratio_bad_i) m_run = 0;
      else if (smp_valid_i) begin
        if (smp_data_i == '0) m_run = (m_run < RUN) ? m_run + 1 : RUN;
        else m_run = 0;
      end
      m_mute = in_reset_i || init_busy_i || pwr_down_i || ratio_bad_i || (m_run >= RUN);
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (mute_o !== m_mute) begin
        errors++;
        $display("FAIL model R6/R8: mute_o=%0b expected %0b at %0t", mute_o, m_mute, $time);
      end
    end
  end

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: mute_o=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [DW-1:0] d);
    smp_valid_i = v;
    smp_data_i  = d;
    @(negedge clk);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; smp_valid_i = 1'b0; smp_data_i = '0;
    in_reset_i = 1'b1; init_busy_i = 1'b0; pwr_down_i = 1'b0; ratio_bad_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", mute_o, 1'b1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 status reset", mute_o, 1'b1);
    in_reset_i = 1'b0;
    drive(1'b0, '0);
    check("R2 release", mute_o, 1'b0);

    zeros(RUN - 1);
    check("R7 one short", mute_o, 1'b0);
    zeros(1);
    check("R6 full run", mute_o, 1'b1);
    zeros(20);
    check("R10 saturate", mute_o, 1'b1);
    drive(1'b1, one_ch(5, 24'h000001));
    check("R8 ch5 nonzero release R11", mute_o, 1'b0);

    zeros(4096);
    for (int i = 0; i < 50; i++) drive(1'b0, one_ch(2, 24'h7FFFFF));
    check("R9 idle gap", mute_o, 1'b0);
    zeros(4095);
    check("R9 one short after gap", mute_o, 1'b0);
    zeros(1);
    check("R9 full across gap", mute_o, 1'b1);

    drive(1'b1, one_ch(0, 24'h800000));
    check("R8 ch0 nonzero", mute_o, 1'b0);
    for (int i = 0; i < RUN + 8; i++) drive(1'b1, one_ch(3, 24'h000100));
    check("R8 partial zero frames", mute_o, 1'b0);

    init_busy_i = 1'b1; drive(1'b0, '0);
    check("R3 init", mute_o, 1'b1);
    init_busy_i = 1'b0; drive(1'b0, '0);
    check("R3 init clear", mute_o, 1'b0);
    pwr_down_i = 1'b1; drive(1'b1, one_ch(4, 24'h000010));
    check("R4 power down", mute_o, 1'b1);
    pwr_down_i = 1'b0; drive(1'b0, '0);
    check("R4 clear", mute_o, 1'b0);

    zeros(8000);
    ratio_bad_i = 1'b1; drive(1'b1, '0);
    check("R5 ratio bad", mute_o, 1'b1);
    ratio_bad_i = 1'b0;
    zeros(192);
    check("R5 run cleared", mute_o, 1'b0);
    zeros(8000);
    check("R5 fresh run", mute_o, 1'b1);

    drive(1'b1, one_ch(1, 24'h000002));
    zeros(8000);
    in_reset_i = 1'b1; drive(1'b0, '0);
    check("R2 status mute", mute_o, 1'b1);
    in_reset_i = 1'b0;
    zeros(192);
    check("R2 run cleared", mute_o, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule